// File: doc/BRIEF.md
# Two-Stage UART Bit-Rate Generator

This block derives the bit timing of a serial port from the system clock. Two programmable dividers are chained. The first stage takes a 16-bit clock divisor and gives a one-cycle sample tick every few reference periods. The second stage takes an 8-bit bit divisor and groups those sample ticks into a baud tick. The reference period is either one system clock or, when the prescale input is high, eight system clocks. The serializer and deserializer use the two ticks. The choice of divisor pair is made elsewhere.

The resulting bit rate is f_clk / (P · CD · (B + 1)). P is 1 or 8. CD is the clock divisor, from 1 to 65535. B is the bit divisor, held to the range 4 to 255. Each divisor is loaded through its own write strobe and data bus. A write to either divisor, or any change of the prescale input, restarts every counter from zero, so no period is ever built from a mix of old and new settings.

A small control machine has two states. ST_HALT is taken out of reset and whenever the clock divisor is written with zero; here no ticks are produced. ST_RUN is taken when the clock divisor is written with a nonzero value. The transitions are HALT_TO_RUN (a nonzero clock-divisor write), RUN_TO_HALT (a zero clock-divisor write), and HOLD (every other cycle, including bit-divisor writes, which leave the state unchanged).

Top module: `uart_baud_gen`

## Requirements
- R1: After reset the clock divisor is 0 and the bit divisor is 4. Both `sample_tick` and `baud_tick` stay low until a nonzero clock divisor is written.
- R2: A reload happens at a clock edge. Let t be the number of rising edges since the last reload. With `presc_sel` low and clock divisor c ≥ 1, `sample_tick` is high exactly in the cycles where t is a positive multiple of c.
- R3: With `presc_sel` high the sample period is 8·c. `sample_tick` is high exactly where t is a positive multiple of 8·c.
- R4: Let B be the effective bit divisor. `baud_tick` is high for one cycle, in the cycle right after every (B+1)-th sample tick counted since the last reload. That is, t−1 is a positive multiple of P·c·(B+1).
- R5: A bit-divisor value from 0 to 3 behaves exactly like 4.
- R6: While the clock divisor is 0, neither tick is ever produced.
- R7: A reload is any cycle where `cd_wr` or `bdiv_wr` is high, or where `presc_sel` differs from its value at the previous edge. A reload clears all counters. Both ticks are low in the cycle after it, and counting restarts at t = 0.
- R8: The full ranges work: clock divisor 65535 and bit divisor 255.
- R9: Writing both divisors in the same cycle loads both values together, with a single reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cd_wr | input | 1 | Write strobe for the clock divisor |
| cd_wdata | input | 16 | New clock divisor (0 halts the generator) |
| bdiv_wr | input | 1 | Write strobe for the bit divisor |
| bdiv_wdata | input | 8 | New bit divisor (values below 4 act as 4) |
| presc_sel | input | 1 | High selects the divide-by-8 reference prescale |
| sample_tick | output | 1 | One-cycle pulse at the oversampling rate |
| baud_tick | output | 1 | One-cycle pulse at the bit rate |

## Verification
The divider chain is driven with several kinds of settings, and each kind isolates one stage:
- Small clock divisors with an unprescaled reference pin down the first stage's period.
- The same divisors with the prescale on tell a wrong ×8 factor apart from a wrong clock-divisor count.
- Bit divisors below, at and above the clamp point separate the clamping from the group count.
- Writes in the middle of a period, including to the bit divisor alone and to both divisors at once, show whether every counter really restarts.
- The extremes 65535 and 255, a zero clock divisor, and randomly drawn divisor pairs with random prescale toggles cover the rest.

// File: rtl/ubg_pkg.sv
package ubg_pkg;

    // control machine states
    typedef enum logic [0:0] {
        ST_HALT = 1'b0,
        ST_RUN  = 1'b1
    } ubg_state_e;

    // smallest usable bit divisor
    localparam int unsigned BDIV_FLOOR = 4;

    // effective bit divisor after clamping
    function automatic logic [7:0] clamp_bdiv(input logic [7:0] raw);
        return (raw < 8'(BDIV_FLOOR)) ? 8'(BDIV_FLOOR) : raw;
    endfunction

endpackage

// File: rtl/ubg_prescale.sv
module ubg_prescale #(
    parameter int unsigned PRE_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload,
    input  logic presc_sel,
    output logic ref_en
);
    localparam int unsigned PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);

    generate
        if (PRE_DIV > 1) begin : g_div
            logic [PW-1:0] cnt_q;
            logic          wrap;

            assign wrap = (cnt_q == LAST);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else if (reload || wrap) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + PW'(1);
                end
            end

            assign ref_en = presc_sel ? wrap : 1'b1;
        end else begin : g_nodiv
            logic unused_in;
            assign unused_in = reload ^ presc_sel;
            assign ref_en    = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/ubg_cd_stage.sv
module ubg_cd_stage #(
    parameter int unsigned CD_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reload,
    input  logic            run,
    input  logic            ref_en,
    input  logic [CD_W-1:0] cd,
    output logic            sample_tick
);
    logic [CD_W-1:0] cnt_q;
    logic            tick_q;
    logic            at_end;

    assign at_end = (cnt_q == (cd - CD_W'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (reload || !run) begin
            cnt_q  <= '0;
            tick_q <= 1'b0;
        end else if (ref_en) begin
            if (at_end) begin
                cnt_q  <= '0;
                tick_q <= 1'b1;
            end else begin
                cnt_q  <= cnt_q + CD_W'(1);
                tick_q <= 1'b0;
            end
        end else begin
            tick_q <= 1'b0;
        end
    end

    assign sample_tick = tick_q;

endmodule

// File: rtl/ubg_bdiv_stage.sv
module ubg_bdiv_stage
    import ubg_pkg::*;
#(
    parameter int unsigned BD_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reload,
    input  logic            sample_tick,
    input  logic [BD_W-1:0] bdiv,
    output logic            baud_tick
);
    logic [BD_W-1:0] cnt_q;
    logic [BD_W-1:0] eff;
    logic            baud_q;

    assign eff = (bdiv < BD_W'(BDIV_FLOOR)) ? BD_W'(BDIV_FLOOR) : bdiv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            baud_q <= 1'b0;
        end else if (reload) begin
            cnt_q  <= '0;
            baud_q <= 1'b0;
        end else if (sample_tick) begin
            if (cnt_q == eff) begin
                cnt_q  <= '0;
                baud_q <= 1'b1;
            end else begin
                cnt_q  <= cnt_q + BD_W'(1);
                baud_q <= 1'b0;
            end
        end else begin
            baud_q <= 1'b0;
        end
    end

    assign baud_tick = baud_q;

endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
    import ubg_pkg::*;
#(
    parameter int unsigned CD_W     = 16,
    parameter int unsigned BD_W     = 8,
    parameter int unsigned PRE_DIV  = 8,
    parameter int unsigned CD_RST   = 0,
    parameter int unsigned BDIV_RST = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cd_wr,
    input  logic [CD_W-1:0] cd_wdata,
    input  logic            bdiv_wr,
    input  logic [BD_W-1:0] bdiv_wdata,
    input  logic            presc_sel,
    output logic            sample_tick,
    output logic            baud_tick
);
    localparam logic [CD_W-1:0] CD_INIT = CD_W'(CD_RST);
    localparam logic [BD_W-1:0] BD_INIT = BD_W'(BDIV_RST);

    ubg_state_e      state_q, state_d;
    logic [CD_W-1:0] cd_q;
    logic [BD_W-1:0] bdiv_q;
    logic            presc_q;
    logic            reload;
    logic            run;
    logic            ref_en;

    // divisor registers and prescale history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cd_q    <= CD_INIT;
            bdiv_q  <= BD_INIT;
            presc_q <= 1'b0;
        end else begin
            if (cd_wr)   cd_q   <= cd_wdata;
            if (bdiv_wr) bdiv_q <= bdiv_wdata;
            presc_q <= presc_sel;
        end
    end

    assign reload = cd_wr | bdiv_wr | (presc_sel ^ presc_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= (CD_INIT == '0) ? ST_HALT : ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (cd_wr && (cd_wdata != '0)) state_d = ST_RUN;
            ST_RUN:  if (cd_wr && (cd_wdata == '0)) state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    // state outputs
    always_comb begin
        run = 1'b0;
        unique case (state_q)
            ST_HALT: run = 1'b0;
            ST_RUN:  run = 1'b1;
            default: run = 1'b0;
        endcase
    end

    ubg_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .reload    (reload),
        .presc_sel (presc_sel),
        .ref_en    (ref_en)
    );

    ubg_cd_stage #(.CD_W(CD_W)) u_cd (
        .clk         (clk),
        .rst_n       (rst_n),
        .reload      (reload),
        .run         (run),
        .ref_en      (ref_en),
        .cd          (cd_q),
        .sample_tick (sample_tick)
    );

    ubg_bdiv_stage #(.BD_W(BD_W)) u_bd (
        .clk         (clk),
        .rst_n       (rst_n),
        .reload      (reload),
        .sample_tick (sample_tick),
        .bdiv        (bdiv_q),
        .baud_tick   (baud_tick)
    );

endmodule

// File: rtl/ubg_checker.sv
module ubg_checker #(
    parameter int unsigned CD_W = 16,
    parameter int unsigned BD_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cd_wr,
    input logic [CD_W-1:0] cd_wdata,
    input logic            bdiv_wr,
    input logic [BD_W-1:0] bdiv_wdata,
    input logic            presc_sel,
    input logic            sample_tick,
    input logic            baud_tick
);
    localparam int unsigned GW = BD_W + 1;

    logic          cd_zero_q;
    logic          presc_seen_q;
    logic          chk_reload;
    logic [GW-1:0] grp_q;
    logic          bd_small;

    assign chk_reload = cd_wr | bdiv_wr | (presc_sel != presc_seen_q);
    assign bd_small   = bdiv_wr && (bdiv_wdata < BD_W'(4));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cd_zero_q    <= 1'b1;
            presc_seen_q <= 1'b0;
            grp_q        <= '0;
        end else begin
            if (cd_wr) cd_zero_q <= (cd_wdata == '0);
            presc_seen_q <= presc_sel;
            if (chk_reload) begin
                grp_q <= '0;
            end else if (baud_tick) begin
                grp_q <= GW'(sample_tick);
            end else if (sample_tick && (grp_q != '1)) begin
                grp_q <= grp_q + GW'(1);
            end
        end
    end

    // R1 / R6: zero clock divisor means silence
    p_halt_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cd_zero_q |-> (!sample_tick && !baud_tick));

    // R7: outputs cleared in the cycle after any divisor write
    p_reload_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cd_wr || bdiv_wr) |=> (!sample_tick && !baud_tick));

    // R4: a baud tick always follows a sample tick
    p_baud_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> $past(sample_tick));

    // R5: a group never has fewer than five sample ticks
    p_group_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |-> (grp_q >= GW'(5)));

    // R3: in prescale mode sample ticks are never adjacent
    p_presc_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (presc_sel && sample_tick) |=> !sample_tick);

    // R7: a clamped write also restarts the group
    p_small_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bd_small |=> !baud_tick);

endmodule

bind uart_baud_gen ubg_checker #(.CD_W(CD_W), .BD_W(BD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cd_wr       (cd_wr),
    .cd_wdata    (cd_wdata),
    .bdiv_wr     (bdiv_wr),
    .bdiv_wdata  (bdiv_wdata),
    .presc_sel   (presc_sel),
    .sample_tick (sample_tick),
    .baud_tick   (baud_tick)
);

// File: tb/sim_uart_baud_gen.sv
`timescale 1ns/1ps
module sim_uart_baud_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cd_wr = 1'b0;
    logic [15:0] cd_wdata = '0;
    logic        bdiv_wr = 1'b0;
    logic [7:0]  bdiv_wdata = '0;
    logic        presc_sel = 1'b0;
    logic        sample_tick;
    logic        baud_tick;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // bench model state
    int unsigned m_cd = 0;
    int unsigned m_bd = 4;
    bit          m_presc = 0;
    int unsigned m_t = 0;

    always #10 clk = ~clk;

    uart_baud_gen u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .cd_wr       (cd_wr),
        .cd_wdata    (cd_wdata),
        .bdiv_wr     (bdiv_wr),
        .bdiv_wdata  (bdiv_wdata),
        .presc_sel   (presc_sel),
        .sample_tick (sample_tick),
        .baud_tick   (baud_tick)
    );

    function automatic bit exp_sample(int unsigned cd, bit pr, int unsigned t);
        int unsigned per;
        per = (pr ? 8 : 1) * cd;
        return (cd != 0) && (t > 0) && ((t % per) == 0);
    endfunction

    function automatic bit exp_baud(int unsigned cd, int unsigned bd, bit pr, int unsigned t);
        int unsigned e;
        int unsigned per;
        e   = (bd < 4) ? 4 : bd;
        per = (pr ? 8 : 1) * cd * (e + 1);
        return (cd != 0) && (t > 1) && (((t - 1) % per) == 0);
    endfunction

    // one clock: drive inputs, advance model, compare outputs
    task automatic cyc(input bit wcd, input logic [15:0] dcd,
                       input bit wbd, input logic [7:0] dbd,
                       input bit pr, input string req);
        bit reload;
        bit es;
        bit eb;
        cd_wr      = wcd;
        cd_wdata   = dcd;
        bdiv_wr    = wbd;
        bdiv_wdata = dbd;
        presc_sel  = pr;
        reload = wcd || wbd || (pr != m_presc);
        @(posedge clk);
        #2;
        if (wcd) m_cd = dcd;
        if (wbd) m_bd = dbd;
        m_presc = pr;
        m_t = reload ? 0 : m_t + 1;
        es = exp_sample(m_cd, m_presc, m_t);
        eb = exp_baud(m_cd, m_bd, m_presc, m_t);
        checks++;
        if (sample_tick !== es || baud_tick !== eb) begin
            failures++;
            $display("FAIL %s t=%0d cd=%0d bd=%0d pr=%0b sample=%0b exp=%0b baud=%0b exp=%0b",
                     req, m_t, m_cd, m_bd, m_presc, sample_tick, es, baud_tick, eb);
        end
        cd_wr   = 1'b0;
        bdiv_wr = 1'b0;
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) cyc(0, '0, 0, '0, m_presc, req);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd1357);
        repeat (4) @(posedge clk);
        #3 rst_n = 1'b1;
        m_t = 0;

        // R1: quiet after reset
        idle(30, "R1");
        // R2, R4: fastest setting
        cyc(1, 16'd1, 0, '0, 0, "R2");
        idle(40, "R4");
        // R5: small bit divisor clamped
        cyc(0, '0, 1, 8'd0, 0, "R5");
        idle(40, "R5");
        cyc(1, 16'd3, 1, 8'd2, 0, "R9");
        idle(70, "R5");
        // R3: prescale on
        cyc(1, 16'd2, 1, 8'd4, 1, "R3");
        idle(200, "R3");
        // R7: mid-period writes and prescale toggle
        cyc(0, '0, 1, 8'd6, 1, "R7");
        idle(37, "R7");
        cyc(0, '0, 0, '0, 0, "R7");
        idle(23, "R7");
        cyc(1, 16'd5, 0, '0, 0, "R7");
        idle(90, "R7");
        // R9: both divisors together
        cyc(1, 16'd2, 1, 8'd5, 0, "R9");
        idle(60, "R9");
        // R6: zero clock divisor halts
        cyc(1, 16'd0, 0, '0, 0, "R6");
        idle(120, "R6");
        cyc(0, '0, 1, 8'd9, 1, "R6");
        idle(120, "R6");
        // R8: maximum bit divisor
        cyc(1, 16'd1, 1, 8'd255, 0, "R8");
        idle(530, "R8");
        // R8: maximum clock divisor
        cyc(1, 16'hFFFF, 1, 8'd4, 0, "R8");
        idle(65540, "R8");

        // random mix, R2 R3 R4 R5 R7
        for (int it = 0; it < 25; it++) begin
            bit          wc;
            bit          wb;
            bit          pr;
            logic [15:0] c;
            logic [7:0]  b;
            wc = ($urandom_range(0, 3) != 0);
            wb = ($urandom_range(0, 2) != 0);
            pr = $urandom_range(0, 1);
            c  = 16'($urandom_range(0, 12));
            if (c == 0 && $urandom_range(0, 3) != 0) c = 16'd1;
            b  = 8'($urandom_range(0, 9));
            cyc(wc, c, wb, b, pr, "R4");
            idle($urandom_range(50, 1500), "R2");
        end

        summary();
    end

endmodule